// File: doc/BRIEF.md
# Interrupt Entry Context Sequencer

This block carries out the hardware work that lies between an interrupt arbitration grant and the first fetch of the service routine. When a grant is accepted, it captures the current status word, instruction pointer, code segment and stack pointer. It then writes the interrupted context onto a system stack that grows toward lower addresses.

The frame has two layouts. With segmentation active, three words are written: the status word, then the code segment, then the instruction pointer. With the segmentation-disable input set, the code segment is left out and only two words are written. After the last push the block presents a new context for one cycle. In that context the priority field of the status word holds the granted level, the instruction pointer holds the vector of the source, and the code segment is zero in segmented mode. In the same cycle it pulses a clear for the serviced source's request flag. One cycle later it pulses done.

The grant arrives on a valid/ready handshake, and grant_ready is high only while the block is idle. A grant is accepted in a cycle where grant_valid and grant_ready are both high. A grant offered while a sequence runs is simply not taken.

The stack writes leave on a valid/ready port. The consumer may hold stk_wr_ready low for any number of cycles. While it does, the sequence stalls and the offered word and address stay unchanged.

Top module: `irq_entry_seq`

## Requirements
- R1: grant_ready is high only while no entry sequence runs, and a grant is taken only when grant_valid and grant_ready are both high. grant_valid held high during a running sequence starts no second sequence and does not change the frame or context of the running one.
- R2: With seg_dis = 0, exactly three words are written, in this order: the status word to sp_in-2, the code segment (zero-extended) to sp_in-4, and the instruction pointer to sp_in-6. sp_out then reads sp_in-6.
- R3: With seg_dis = 1, exactly two words are written: the status word to sp_in-2, then the instruction pointer to sp_in-4. sp_out then reads sp_in-4.
- R4: The status word written to the stack is the value from before entry. psw_out during ctx_load equals that value with bits [15:12] replaced by grant_lvl, and all other bits unchanged.
- R5: During ctx_load, ip_out equals grant_src multiplied by 4. csp_out is zero when seg_dis = 0 and equals the captured csp_in when seg_dis = 1.
- R6: clr_req is high for exactly one cycle per sequence, in the same cycle as ctx_load, with clr_src equal to the granted source index.
- R7: done is high for exactly one cycle, in the cycle after ctx_load, and grant_ready is high again in the cycle after done.
- R8: While stk_wr_valid is high and stk_wr_ready is low, stk_wr_valid stays high and stk_wr_addr and stk_wr_data hold their values. Each word advances only on a completed handshake.
- R9: A push whose address is below stk_limit sets stk_ovf, and the push is still performed. stk_ovf stays set until reset.
- R10: After reset, grant_ready is 1 and stk_wr_valid, ctx_load, clr_req, done and stk_ovf are 0, and sp_out is 0.
- R11: psw_in, ip_in, csp_in, sp_in, grant_src, grant_lvl and seg_dis are sampled only in the accept cycle. Later changes to these inputs do not alter the frame or the context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_valid | input | 1 | Arbitration grant offered |
| grant_ready | output | 1 | Block idle, grant can be taken |
| grant_src | input | SRC_W | Index of the granted source |
| grant_lvl | input | LVL_W | Priority level of the granted request |
| seg_dis | input | 1 | 1 selects the short (non-segmented) frame |
| psw_in | input | W | Current status word |
| ip_in | input | W | Current instruction pointer (return address) |
| csp_in | input | CSP_W | Current code segment |
| sp_in | input | W | Current stack pointer |
| stk_limit | input | W | Lowest legal stack address |
| stk_wr_valid | output | 1 | Stack word offered |
| stk_wr_ready | input | 1 | Stack memory accepts the word |
| stk_wr_addr | output | W | Byte address of the stack word |
| stk_wr_data | output | W | Stack word |
| sp_out | output | W | Stack pointer after the pushes made so far |
| stk_ovf | output | 1 | Sticky stack-overflow flag |
| ctx_load | output | 1 | One-cycle strobe: load psw_out, ip_out, csp_out |
| psw_out | output | W | Status word with raised priority |
| ip_out | output | W | Vector address |
| csp_out | output | CSP_W | New code segment |
| clr_req | output | 1 | One-cycle strobe: clear request flag |
| clr_src | output | SRC_W | Source whose request flag is cleared |
| done | output | 1 | One-cycle end-of-entry strobe |

## Verification
The main sequence runs against a table of grants that alternates the two frame lengths, so the number of words, their order and the final stack pointer separate the segmented layout from the short one. Source indices at zero and at the maximum, and levels at 0 and 15, check the vector scaling and the priority-field insert at their edges. Status words of all ones and all zeros show that only bits [15:12] change. Some entries stall the write port every other cycle, which tells a held word apart from one that moves early. In other entries grant_valid stays high with changed inputs during the sequence, which exposes a second acceptance or late sampling. Directed runs place the stack so that only the last push falls below the limit, and then show that the flag survives a clean sequence and is cleared only by reset.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SLOT_PSW = 2'd0,
    SLOT_CSP = 2'd1,
    SLOT_IP  = 2'd2
  } frame_slot_e;
endpackage

// File: rtl/irq_grant_latch.sv
module irq_grant_latch #(
  parameter int W     = 16,
  parameter int CSP_W = 8,
  parameter int SRC_W = 5,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [W-1:0]     psw_in,
  input  logic [W-1:0]     ip_in,
  input  logic [CSP_W-1:0] csp_in,
  input  logic [SRC_W-1:0] src_in,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             seg_dis_in,
  output logic [W-1:0]     psw_q,
  output logic [W-1:0]     ip_q,
  output logic [CSP_W-1:0] csp_q,
  output logic [SRC_W-1:0] src_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             seg_dis_q
);
  // Context is frozen at the accept edge; later input changes are not seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q     <= '0;
      ip_q      <= '0;
      csp_q     <= '0;
      src_q     <= '0;
      lvl_q     <= '0;
      seg_dis_q <= 1'b0;
    end else if (take) begin
      psw_q     <= psw_in;
      ip_q      <= ip_in;
      csp_q     <= csp_in;
      src_q     <= src_in;
      lvl_q     <= lvl_in;
      seg_dis_q <= seg_dis_in;
    end
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        grant_valid,
  input  logic        seg_dis_q,
  input  logic        push_fire,
  output logic        grant_ready,
  output logic        take,
  output logic        push_req,
  output frame_slot_e slot,
  output logic        ctx_load,
  output logic        done
);
  seq_state_e state_q;
  frame_slot_e slot_q;

  assign grant_ready = (state_q == ST_IDLE);
  assign take        = grant_valid && grant_ready;
  assign push_req    = (state_q == ST_PUSH);
  assign ctx_load    = (state_q == ST_LOAD);
  assign done        = (state_q == ST_DONE);
  assign slot        = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= SLOT_PSW;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_PUSH;
          slot_q  <= SLOT_PSW;
        end
        ST_PUSH: if (push_fire) begin
          case (slot_q)
            SLOT_PSW: slot_q  <= seg_dis_q ? SLOT_IP : SLOT_CSP;
            SLOT_CSP: slot_q  <= SLOT_IP;
            default:  state_q <= ST_LOAD;
          endcase
        end
        ST_LOAD: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready) |=> !grant_ready);
  assert_done_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> (done && !ctx_load));
  assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> grant_ready);
endmodule

// File: rtl/irq_stack_pusher.sv
module irq_stack_pusher #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] limit,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         wr_ready,
  output logic         wr_valid,
  output logic [W-1:0] wr_addr,
  output logic [W-1:0] wr_data,
  output logic         push_fire,
  output logic [W-1:0] sp_out,
  output logic         ovf
);
  localparam logic [W-1:0] WORD_BYTES = W'(W / 8);

  logic [W-1:0] sp_q;
  logic [W-1:0] next_sp;
  logic         ovf_q;

  assign next_sp   = sp_q - WORD_BYTES;
  assign wr_valid  = push_req;
  assign wr_addr   = next_sp;
  assign wr_data   = push_data;
  assign push_fire = push_req && wr_ready;
  assign sp_out    = sp_q;
  assign ovf       = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
    end else if (start) begin
      sp_q <= sp_in;
    end else if (push_fire) begin
      sp_q <= next_sp;
      if (next_sp < limit) ovf_q <= 1'b1;
    end
  end

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (sp_out == $past(wr_addr)));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/irq_ctx_build.sv
module irq_ctx_build
  import irq_seq_pkg::*;
#(
  parameter int W         = 16,
  parameter int CSP_W     = 8,
  parameter int SRC_W     = 5,
  parameter int LVL_W     = 4,
  parameter int ILVL_LSB  = 12,
  parameter int VEC_SHIFT = 2
) (
  input  logic [W-1:0]     psw_q,
  input  logic [W-1:0]     ip_q,
  input  logic [CSP_W-1:0] csp_q,
  input  logic [SRC_W-1:0] src_q,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic             seg_dis_q,
  input  frame_slot_e      slot,
  output logic [W-1:0]     push_data,
  output logic [W-1:0]     psw_out,
  output logic [W-1:0]     ip_out,
  output logic [CSP_W-1:0] csp_out
);
  always_comb begin
    psw_out = psw_q;
    psw_out[ILVL_LSB +: LVL_W] = lvl_q;
  end

  assign ip_out  = W'(src_q) << VEC_SHIFT;
  assign csp_out = seg_dis_q ? csp_q : '0;

  always_comb begin
    case (slot)
      SLOT_CSP: push_data = W'(csp_q);
      SLOT_IP:  push_data = ip_q;
      default:  push_data = psw_q;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int W         = 16,
  parameter int CSP_W     = 8,
  parameter int SRC_W     = 5,
  parameter int LVL_W     = 4,
  parameter int ILVL_LSB  = 12,
  parameter int VEC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_valid,
  output logic             grant_ready,
  input  logic [SRC_W-1:0] grant_src,
  input  logic [LVL_W-1:0] grant_lvl,
  input  logic             seg_dis,
  input  logic [W-1:0]     psw_in,
  input  logic [W-1:0]     ip_in,
  input  logic [CSP_W-1:0] csp_in,
  input  logic [W-1:0]     sp_in,
  input  logic [W-1:0]     stk_limit,
  output logic             stk_wr_valid,
  input  logic             stk_wr_ready,
  output logic [W-1:0]     stk_wr_addr,
  output logic [W-1:0]     stk_wr_data,
  output logic [W-1:0]     sp_out,
  output logic             stk_ovf,
  output logic             ctx_load,
  output logic [W-1:0]     psw_out,
  output logic [W-1:0]     ip_out,
  output logic [CSP_W-1:0] csp_out,
  output logic             clr_req,
  output logic [SRC_W-1:0] clr_src,
  output logic             done
);
  logic             take, push_req, push_fire;
  frame_slot_e      slot;
  logic [W-1:0]     psw_q, ip_q, push_data;
  logic [CSP_W-1:0] csp_q;
  logic [SRC_W-1:0] src_q;
  logic [LVL_W-1:0] lvl_q;
  logic             seg_dis_q;

  irq_grant_latch #(.W(W), .CSP_W(CSP_W), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take),
    .psw_in(psw_in), .ip_in(ip_in), .csp_in(csp_in),
    .src_in(grant_src), .lvl_in(grant_lvl), .seg_dis_in(seg_dis),
    .psw_q(psw_q), .ip_q(ip_q), .csp_q(csp_q),
    .src_q(src_q), .lvl_q(lvl_q), .seg_dis_q(seg_dis_q)
  );

  irq_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid),
    .seg_dis_q(seg_dis_q), .push_fire(push_fire),
    .grant_ready(grant_ready), .take(take), .push_req(push_req),
    .slot(slot), .ctx_load(ctx_load), .done(done)
  );

  irq_stack_pusher #(.W(W)) u_push (
    .clk(clk), .rst_n(rst_n), .start(take), .sp_in(sp_in), .limit(stk_limit),
    .push_req(push_req), .push_data(push_data), .wr_ready(stk_wr_ready),
    .wr_valid(stk_wr_valid), .wr_addr(stk_wr_addr), .wr_data(stk_wr_data),
    .push_fire(push_fire), .sp_out(sp_out), .ovf(stk_ovf)
  );

  irq_ctx_build #(.W(W), .CSP_W(CSP_W), .SRC_W(SRC_W), .LVL_W(LVL_W),
                  .ILVL_LSB(ILVL_LSB), .VEC_SHIFT(VEC_SHIFT)) u_ctx (
    .psw_q(psw_q), .ip_q(ip_q), .csp_q(csp_q), .src_q(src_q), .lvl_q(lvl_q),
    .seg_dis_q(seg_dis_q), .slot(slot), .push_data(push_data),
    .psw_out(psw_out), .ip_out(ip_out), .csp_out(csp_out)
  );

  assign clr_req = ctx_load;
  assign clr_src = src_q;

  assert_vec_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> (ip_out[VEC_SHIFT-1:0] == '0));
  assert_seg_csp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && !seg_dis_q) |-> (csp_out == '0));
  assert_no_write_at_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> !stk_wr_valid);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        grant_valid = 1'b0, seg_dis = 1'b0, stk_wr_ready = 1'b1;
  logic [4:0]  grant_src = '0;
  logic [3:0]  grant_lvl = '0;
  logic [15:0] psw_in = '0, ip_in = '0, sp_in = '0, stk_limit = '0;
  logic [7:0]  csp_in = '0;
  logic        grant_ready, stk_wr_valid, stk_ovf, ctx_load, clr_req, done;
  logic [15:0] stk_wr_addr, stk_wr_data, sp_out, psw_out, ip_out;
  logic [7:0]  csp_out;
  logic [4:0]  clr_src;

  irq_entry_seq u_irq_entry_seq (.*);

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nwr = 0, n_acc = 0, n_clr = 0, ld_cyc = -1, dn_cyc = -1, n_done = 0, hold_err = 0;
  logic [15:0] wa [0:7];
  logic [15:0] wd [0:7];
  logic [15:0] c_psw, c_ip, c_sp;
  logic [7:0]  c_csp;
  logic [4:0]  c_src;
  logic        stall_mode = 1'b0;
  logic        prev_stall = 1'b0;
  logic [15:0] prev_a, prev_d;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2 stk_wr_ready = stall_mode ? !stk_wr_ready : 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (grant_valid && grant_ready) n_acc++;
    if (prev_stall && (stk_wr_addr != prev_a || stk_wr_data != prev_d || !stk_wr_valid)) hold_err++;
    prev_stall = stk_wr_valid && !stk_wr_ready;
    prev_a = stk_wr_addr;
    prev_d = stk_wr_data;
    if (stk_wr_valid && stk_wr_ready) begin
      if (nwr < 8) begin wa[nwr] = stk_wr_addr; wd[nwr] = stk_wr_data; end
      nwr++;
    end
    if (ctx_load) begin
      ld_cyc = cyc; c_psw = psw_out; c_ip = ip_out; c_csp = csp_out; c_sp = sp_out;
    end
    if (clr_req) begin n_clr++; c_src = clr_src; end
    if (done) begin dn_cyc = cyc; n_done++; end
  end

  // entry: {hold, stall, seg_dis, src[4:0], lvl[3:0], psw, ip, csp, sp}
  localparam int NV = 6;
  localparam logic [67:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 1'b0, 5'd3,  4'd5,  16'h0A5C, 16'h1234, 8'h07, 16'hFC00},
    {1'b0, 1'b0, 1'b1, 5'd31, 4'd15, 16'hF001, 16'hBEEF, 8'h3C, 16'hFA10},
    {1'b0, 1'b1, 1'b0, 5'd0,  4'd1,  16'h0000, 16'h0002, 8'hFF, 16'hFC80},
    {1'b1, 1'b1, 1'b1, 5'd17, 4'd14, 16'h7FFF, 16'h8000, 8'h01, 16'hF800},
    {1'b1, 1'b0, 1'b0, 5'd12, 4'd0,  16'hFFFF, 16'hFFFE, 8'h80, 16'hFD00},
    {1'b0, 1'b0, 1'b1, 5'd1,  4'd8,  16'h5555, 16'h0000, 8'h00, 16'h0800}
  };

  task automatic run_entry(input logic hold, input logic stall, input logic sd, input logic [4:0] src,
                           input logic [3:0] lvl, input logic [15:0] psw, input logic [15:0] ip,
                           input logic [7:0] csp, input logic [15:0] sp, input string tag);
    int exp_n;
    logic [15:0] exp_d [0:2];
    nwr = 0; n_acc = 0; n_clr = 0; ld_cyc = -1; dn_cyc = -1; n_done = 0; hold_err = 0;
    stall_mode = stall;
    @(posedge clk); #2;
    seg_dis = sd; grant_src = src; grant_lvl = lvl; psw_in = psw; ip_in = ip; csp_in = csp; sp_in = sp;
    grant_valid = 1'b1;
    @(posedge clk); #2;
    // R11: change every captured input right after the accept edge
    seg_dis = !sd; grant_src = src + 5'd1; grant_lvl = ~lvl; psw_in = ~psw; ip_in = ~ip;
    csp_in = ~csp; sp_in = sp ^ 16'h0F0F;
    grant_valid = hold;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) break;
    end
    grant_valid = 1'b0;
    @(negedge clk);
    stall_mode = 1'b0;
    chk(grant_ready == 1'b1, {tag, " R7 ready after done"}, grant_ready, 1);
    chk(n_done == 1, {tag, " R7 done count"}, n_done, 1);
    chk(dn_cyc == ld_cyc + 1, {tag, " R7 done one cycle after load"}, dn_cyc, ld_cyc + 1);
    chk(n_acc == 1, {tag, " R1 single accept"}, n_acc, 1);
    exp_n = sd ? 2 : 3;
    exp_d[0] = psw;
    exp_d[1] = sd ? ip : {8'h00, csp};
    exp_d[2] = ip;
    chk(nwr == exp_n, {tag, sd ? " R3 frame length" : " R2 frame length"}, nwr, exp_n);
    for (int j = 0; j < exp_n; j++) begin
      chk(wa[j] == sp - 16'(2 * (j + 1)), {tag, sd ? " R3 push addr" : " R2 push addr"}, wa[j], sp - 16'(2 * (j + 1)));
      chk(wd[j] == exp_d[j], {tag, sd ? " R3 push data R11" : " R2 push data R11"}, wd[j], exp_d[j]);
    end
    chk(c_sp == sp - 16'(2 * exp_n), {tag, " R2 R3 final sp"}, c_sp, sp - 16'(2 * exp_n));
    chk(c_psw == {lvl, psw[11:0]}, {tag, " R4 psw_out level"}, c_psw, {lvl, psw[11:0]});
    chk(c_ip == {9'd0, src, 2'b00}, {tag, " R5 vector"}, c_ip, {9'd0, src, 2'b00});
    chk(c_csp == (sd ? csp : 8'h00), {tag, " R5 csp_out"}, c_csp, sd ? csp : 8'h00);
    chk(n_clr == 1 && c_src == src, {tag, " R6 clear strobe"}, {n_clr[7:0], 3'b0, c_src}, {8'd1, 3'b0, src});
    chk(hold_err == 0, {tag, " R8 stalled word held"}, hold_err, 0);
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(grant_ready == 1'b1, "R10 grant_ready", grant_ready, 1);
    chk(!stk_wr_valid && !ctx_load && !clr_req && !done, "R10 strobes low",
        {stk_wr_valid, ctx_load, clr_req, done}, 0);
    chk(stk_ovf == 1'b0, "R10 ovf clear", stk_ovf, 0);
    chk(sp_out == 16'h0, "R10 sp_out", sp_out, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [67:0] e;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      run_entry(e[67], e[66], e[65], e[64:60], e[59:56], e[55:40], e[39:24], e[23:16], e[15:0],
                $sformatf("vec%0d", i));
      chk(stk_ovf == 1'b0, "R9 no overflow above limit", stk_ovf, 0);
    end
    // R9: only the third push (0xEFFE) lies below the limit 0xF000
    stk_limit = 16'hF000;
    run_entry(1'b0, 1'b0, 1'b0, 5'd9, 4'd6, 16'h1234, 16'h4321, 8'h22, 16'hF004, "ovf");
    chk(stk_ovf == 1'b1, "R9 overflow set", stk_ovf, 1);
    chk(wa[2] == 16'hEFFE, "R9 push still performed", wa[2], 16'hEFFE);
    stk_limit = 16'h0000;
    run_entry(1'b0, 1'b0, 1'b1, 5'd2, 4'd3, 16'h0101, 16'h0202, 8'h03, 16'hFC00, "sticky");
    chk(stk_ovf == 1'b1, "R9 overflow sticky", stk_ovf, 1);
    // R9 boundary: push exactly at the limit does not flag
    do_reset();
    stk_limit = 16'hF000;
    run_entry(1'b0, 1'b0, 1'b1, 5'd4, 4'd2, 16'h0F0F, 16'h00AA, 8'h00, 16'hF004, "edge");
    chk(stk_ovf == 1'b0, "R9 push at limit not flagged", stk_ovf, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule